// File: doc/BRIEF.md
# Auto-Incrementing RAM Disk Port Controller

This block lets a host processor reach a bank of eight byte-wide storage units through just two I/O ports. One port builds a 22-bit byte address. The host writes three bytes to it, most significant first, and each write shifts the earlier bytes up. The other port moves one byte per access to or from the location that address names. After every data access the address advances by one, so the host can stream a long run of bytes without reloading it.

The top three address bits choose the unit and the lower nineteen bits give the byte offset inside that unit. Because the increment runs through the unit field, a transfer that passes the last byte of one unit carries on at offset zero of the next unit. The full address wraps to zero after its highest value.

Each unit has a presence input and a write-lock input, both sampled in the cycle of the access. A read from an absent unit returns all ones. A write to an absent or locked unit leaves storage untouched. In both cases the address still advances.

The storage itself sits outside the block, behind a request interface with one cycle of read latency. The parameter `OFFSET_W` sets how many offset bits are driven to the storage, so a simulation can use small memories. Offset bits above `OFFSET_W` are still held and incremented in the address register.

Top module: `ramdisk_port_ctrl`

## Requirements
- R1: A host access is one cycle with `ioSel` high. `ioPort`=1 selects the address port and `ioPort`=0 selects the data port. In a cycle with `ioSel` low there is no storage request, no read return follows, and the address is unchanged.
- R2: A write to the address port makes the new address equal to the old address shifted left by eight bits, truncated to 22 bits, with the written byte in bits 7:0. Three writes of bytes A, B, C therefore give the address {A[5:0],B,C}, and a fourth write pushes the oldest byte out.
- R3: During a data-port access to a present unit, `memUnit` equals address bits 21:19 and `memOffset` equals address bits `OFFSET_W`-1:0, both in the same cycle as the strobe.
- R4: Every data-port access, whether read or write and whatever the unit's state, adds one to the address modulo 2^22. Offset 0x7FFFF of unit n is followed by offset 0 of unit n+1, and address 0x3FFFFF is followed by 0.
- R5: A read of the address port returns 0xFF and leaves the address unchanged.
- R6: A data-port read of a present unit raises `memReq` with `memWe`=0 and returns the stored byte on `ioRdata` one cycle later. A data-port read of a unit whose `unitPresent` bit is 0 raises no request and returns 0xFF.
- R7: A data-port write raises `memReq` with `memWe`=1 and `memWdata` equal to the written byte only when the unit's `unitPresent` bit is 1 and its `unitLocked` bit is 0. Otherwise no request is made and storage keeps its contents.
- R8: `ioRvalid` is high in exactly the cycle after each read strobe to either port, and low in every other cycle.
- R9: Reset clears the address to 0 and holds `ioRvalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioSel | input | 1 | One-cycle host access strobe |
| ioWr | input | 1 | 1 = write access, 0 = read access |
| ioPort | input | 1 | Port select: 1 = address port, 0 = data port |
| ioWdata | input | 8 | Byte written by the host |
| unitPresent | input | 8 | Per-unit presence flags |
| unitLocked | input | 8 | Per-unit write-lock flags |
| ioRdata | output | 8 | Read return byte |
| ioRvalid | output | 1 | Read return valid, one cycle after a read strobe |
| memReq | output | 1 | Storage request |
| memWe | output | 1 | Storage write enable |
| memUnit | output | 3 | Storage unit index |
| memOffset | output | OFFSET_W | Storage byte offset |
| memWdata | output | 8 | Storage write byte |
| memRdata | input | 8 | Storage read byte, valid one cycle after a read request |

## Verification
The storage request outputs appear in the same cycle as the host strobe. The bench checks them one time step after it drives the strobe, before the clock edge. Read data and `ioRvalid` are due one cycle after the strobe, so the bench checks them at the next falling edge, when it drives the following access. Address changes cannot be seen at the ports directly. The bench infers them from the unit and offset shown on the next data access, or from the byte that access returns, and compares these with a behavioural model that advances on every access.

// File: rtl/ramdisk_pkg.sv
package ramdisk_pkg;
  // Strobes passed from the decode control to the datapath in one cycle.
  typedef struct packed {
    logic addrLoad;   // shift a byte into the address register
    logic addrStep;   // advance the address after a data access
    logic memRead;    // issue a storage read
    logic memWrite;   // issue a storage write
    logic rdReturn;   // a read is returned next cycle
    logic rdFromMem;  // the returned byte comes from storage
  } ctrlStrobe_t;
endpackage

// File: rtl/ramdisk_ctrl.sv
module ramdisk_ctrl
  import ramdisk_pkg::*;
#(
  parameter int UNIT_W = 3,
  localparam int NUM_UNITS = 1 << UNIT_W
) (
  input  logic                 ioSel,
  input  logic                 ioWr,
  input  logic                 ioPort,
  input  logic [UNIT_W-1:0]    curUnit,
  input  logic [NUM_UNITS-1:0] unitPresent,
  input  logic [NUM_UNITS-1:0] unitLocked,
  output ctrlStrobe_t          strobe
);
  logic dataAccess;
  logic unitOnline;
  logic unitWritable;

  always_comb begin
    dataAccess   = ioSel && !ioPort;
    unitOnline   = unitPresent[curUnit];
    unitWritable = unitOnline && !unitLocked[curUnit];

    strobe.addrLoad  = ioSel && ioWr && ioPort;
    strobe.addrStep  = dataAccess;
    strobe.memRead   = dataAccess && !ioWr && unitOnline;
    strobe.memWrite  = dataAccess && ioWr && unitWritable;
    strobe.rdReturn  = ioSel && !ioWr;
    strobe.rdFromMem = dataAccess && !ioWr && unitOnline;
  end
endmodule

// File: rtl/ramdisk_datapath.sv
module ramdisk_datapath
  import ramdisk_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int UNIT_W   = 3,
  parameter int OFFSET_W = 19,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [DATA_W-1:0]   ioWdata,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   curAddr,
  output logic [UNIT_W-1:0]   curUnit,
  output logic [OFFSET_W-1:0] curOffset,
  output logic [DATA_W-1:0]   ioRdata,
  output logic                ioRvalid
);
  localparam int KEEP_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic              rvalidQ;
  logic              fromMemQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.addrLoad) begin
      addrQ <= {addrQ[KEEP_W-1:0], ioWdata};
    end else if (strobe.addrStep) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rvalidQ  <= 1'b0;
      fromMemQ <= 1'b0;
    end else begin
      rvalidQ  <= strobe.rdReturn;
      fromMemQ <= strobe.rdFromMem;
    end
  end

  always_comb begin
    curAddr   = addrQ;
    curUnit   = addrQ[ADDR_W-1 -: UNIT_W];
    curOffset = addrQ[OFFSET_W-1:0];
    ioRvalid  = rvalidQ;
    ioRdata   = fromMemQ ? memRdata : '1;
  end
endmodule

// File: rtl/ramdisk_port_ctrl.sv
module ramdisk_port_ctrl
  import ramdisk_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int UNIT_W   = 3,
  parameter int OFFSET_W = 19,
  parameter int DATA_W   = 8,
  localparam int NUM_UNITS = 1 << UNIT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ioSel,
  input  logic                 ioWr,
  input  logic                 ioPort,
  input  logic [DATA_W-1:0]    ioWdata,
  input  logic [NUM_UNITS-1:0] unitPresent,
  input  logic [NUM_UNITS-1:0] unitLocked,
  output logic [DATA_W-1:0]    ioRdata,
  output logic                 ioRvalid,
  output logic                 memReq,
  output logic                 memWe,
  output logic [UNIT_W-1:0]    memUnit,
  output logic [OFFSET_W-1:0]  memOffset,
  output logic [DATA_W-1:0]    memWdata,
  input  logic [DATA_W-1:0]    memRdata
);
  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] curAddr;
  logic [UNIT_W-1:0] curUnit;

  ramdisk_ctrl #(.UNIT_W(UNIT_W)) u_ctrl (
    .ioSel       (ioSel),
    .ioWr        (ioWr),
    .ioPort      (ioPort),
    .curUnit     (curUnit),
    .unitPresent (unitPresent),
    .unitLocked  (unitLocked),
    .strobe      (strobe)
  );

  ramdisk_datapath #(
    .ADDR_W   (ADDR_W),
    .UNIT_W   (UNIT_W),
    .OFFSET_W (OFFSET_W),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ioWdata   (ioWdata),
    .memRdata  (memRdata),
    .curAddr   (curAddr),
    .curUnit   (curUnit),
    .curOffset (memOffset),
    .ioRdata   (ioRdata),
    .ioRvalid  (ioRvalid)
  );

  always_comb begin
    memReq   = strobe.memRead || strobe.memWrite;
    memWe    = strobe.memWrite;
    memUnit  = curUnit;
    memWdata = ioWdata;
  end
endmodule

// File: rtl/ramdisk_port_ctrl_chk.sv
module ramdisk_port_ctrl_chk #(
  parameter int ADDR_W   = 22,
  parameter int UNIT_W   = 3,
  parameter int DATA_W   = 8,
  localparam int NUM_UNITS = 1 << UNIT_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ioSel,
  input logic                 ioWr,
  input logic                 ioPort,
  input logic [DATA_W-1:0]    ioWdata,
  input logic [NUM_UNITS-1:0] unitPresent,
  input logic [NUM_UNITS-1:0] unitLocked,
  input logic                 memReq,
  input logic                 memWe,
  input logic [UNIT_W-1:0]    memUnit,
  input logic [DATA_W-1:0]    ioRdata,
  input logic                 ioRvalid,
  input logic [ADDR_W-1:0]    curAddr
);
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !ioSel |=> $stable(curAddr) && !ioRvalid);

  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !ioSel |-> !memReq);

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rstN)
    (ioSel && ioWr && ioPort) |=>
      (curAddr[DATA_W-1:0] == $past(ioWdata)) &&
      (curAddr[ADDR_W-1:DATA_W] == $past(curAddr[ADDR_W-DATA_W-1:0])));

  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    (ioSel && !ioPort) |=> curAddr == ADDR_W'($past(curAddr) + 1'b1));

  a_r5_port1_read: assert property (@(posedge clk) disable iff (!rstN)
    (ioSel && !ioWr && ioPort) |=> $stable(curAddr) && ioRdata == '1);

  a_r6_absent_no_req: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> unitPresent[memUnit] && ioSel && !ioPort);

  a_r7_lock_blocks: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq && ioWr && !unitLocked[memUnit]);

  a_r8_rvalid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (ioSel && !ioWr) |=> ioRvalid);

  a_r8_no_rvalid_else: assert property (@(posedge clk) disable iff (!rstN)
    !(ioSel && !ioWr) |=> !ioRvalid);
endmodule

bind ramdisk_port_ctrl ramdisk_port_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .UNIT_W (UNIT_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ioSel       (ioSel),
  .ioWr        (ioWr),
  .ioPort      (ioPort),
  .ioWdata     (ioWdata),
  .unitPresent (unitPresent),
  .unitLocked  (unitLocked),
  .memReq      (memReq),
  .memWe       (memWe),
  .memUnit     (memUnit),
  .ioRdata     (ioRdata),
  .ioRvalid    (ioRvalid),
  .curAddr     (curAddr)
);

// File: tb/ramdisk_port_ctrl_tb.sv
`timescale 1ns/1ps
module ramdisk_port_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       ioSel, ioWr, ioPort;
  logic [7:0] ioWdata;
  logic [7:0] unitPresent, unitLocked;
  logic [7:0] ioRdata;
  logic       ioRvalid;
  logic       memReq, memWe;
  logic [2:0] memUnit;
  logic [18:0] memOffset;
  logic [7:0] memWdata;
  logic [7:0] memRdata;

  always #2 clk = ~clk;

  ramdisk_port_ctrl u_dut (
    .clk(clk), .rstN(rstN), .ioSel(ioSel), .ioWr(ioWr), .ioPort(ioPort),
    .ioWdata(ioWdata), .unitPresent(unitPresent), .unitLocked(unitLocked),
    .ioRdata(ioRdata), .ioRvalid(ioRvalid), .memReq(memReq), .memWe(memWe),
    .memUnit(memUnit), .memOffset(memOffset), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  // Storage behind the request interface: one-cycle read latency.
  logic [7:0] memStore [int];
  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) memStore[{memUnit, memOffset}] = memWdata;
      else memRdata <= memStore.exists({memUnit, memOffset}) ?
                       memStore[{memUnit, memOffset}] : 8'h00;
    end
  end

  // Reference model
  logic [7:0] expStore [int];
  int         expAddr;
  bit         expRv;
  logic [7:0] expRd;
  string      expTag;
  int         nChecks = 0;
  int         nFails = 0;
  bit         summaryDone = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkReturn();
    check(ioRvalid == expRv, "R8", int'(ioRvalid), int'(expRv));
    if (expRv) check(ioRdata == expRd, expTag, int'(ioRdata), int'(expRd));
  endtask

  task automatic idle();
    checkReturn();
    ioSel = 0; ioWr = 0; ioPort = 0; ioWdata = 8'h00;
    #1;
    check(memReq == 1'b0, "R1", int'(memReq), 0);
    expRv = 0;
    @(negedge clk);
  endtask

  task automatic op(input bit wr, input bit port, input logic [7:0] d, input string tag);
    int unitIdx, off, key;
    bit present, wrOk;
    checkReturn();
    ioSel = 1; ioWr = wr; ioPort = port; ioWdata = d;
    #1;
    expRv = 0;
    if (port) begin
      check(memReq == 1'b0, tag, int'(memReq), 0);
      if (wr) expAddr = ((expAddr << 8) | int'(d)) & 32'h3FFFFF;
      else begin expRv = 1; expRd = 8'hFF; expTag = "R5"; end
    end else begin
      unitIdx = (expAddr >> 19) & 7;
      off     = expAddr & 32'h7FFFF;
      key     = (unitIdx << 19) | off;
      present = unitPresent[unitIdx];
      wrOk    = present && !unitLocked[unitIdx];
      if (wr) begin
        check(memReq == wrOk, tag, int'(memReq), int'(wrOk));
        if (wrOk) begin
          check(memWe == 1'b1 && memWdata == d, "R7", int'(memWdata), int'(d));
          expStore[key] = d;
        end
      end else begin
        check(memReq == present && !memWe, tag, int'(memReq), int'(present));
        expRv = 1; expTag = tag;
        expRd = !present ? 8'hFF : (expStore.exists(key) ? expStore[key] : 8'h00);
      end
      if ((wr && wrOk) || (!wr && present)) begin
        check(memUnit == unitIdx[2:0], "R3", int'(memUnit), unitIdx);
        check(memOffset == off[18:0], tag, int'(memOffset), off);
      end
      expAddr = (expAddr + 1) & 32'h3FFFFF;
    end
    @(negedge clk);
  endtask

  task automatic loadAddr(input logic [7:0] b2, input logic [7:0] b1, input logic [7:0] b0);
    op(1, 1, b2, "R2"); op(1, 1, b1, "R2"); op(1, 1, b0, "R2");
  endtask

  initial begin
    ioSel = 0; ioWr = 0; ioPort = 0; ioWdata = 0;
    unitPresent = 8'hFF; unitLocked = 8'h00;
    expAddr = 0; expRv = 0; expRd = 8'hFF; expTag = "R8";
    rstN = 0;
    repeat (3) @(negedge clk);
    check(ioRvalid == 1'b0, "R9", int'(ioRvalid), 0);
    rstN = 1;
    @(negedge clk);
    // R9: first data access after reset is at address 0
    op(0, 0, 8'h00, "R9");
    idle();
    // R2: shift order, MSB first; fourth byte pushes the oldest out
    loadAddr(8'h12, 8'h34, 8'h56);
    op(1, 0, 8'hA1, "R2");
    op(1, 1, 8'h78, "R2");
    op(1, 0, 8'hA2, "R2");
    loadAddr(8'h12, 8'h34, 8'h56);
    op(0, 0, 8'h00, "R6");
    loadAddr(8'h34, 8'h56, 8'h78);
    op(0, 0, 8'h00, "R6");
    // R5: address port read returns 0xFF, address unchanged
    loadAddr(8'h00, 8'h00, 8'h40);
    op(1, 0, 8'h5A, "R7");
    op(0, 1, 8'h00, "R5");
    op(0, 1, 8'h00, "R5");
    op(0, 0, 8'h00, "R5");
    // R4: rollover unit 1 -> unit 2
    loadAddr(8'h0F, 8'hFF, 8'hFE);
    op(1, 0, 8'hC1, "R4");
    op(1, 0, 8'hC2, "R4");
    op(1, 0, 8'hC3, "R4");
    loadAddr(8'h0F, 8'hFF, 8'hFE);
    op(0, 0, 8'h00, "R4");
    op(0, 0, 8'h00, "R4");
    op(0, 0, 8'h00, "R4");
    // R4: wrap at 0x3FFFFF to 0
    loadAddr(8'h3F, 8'hFF, 8'hFE);
    op(1, 0, 8'hE1, "R4");
    op(1, 0, 8'hE2, "R4");
    op(1, 0, 8'hE3, "R4");
    loadAddr(8'h3F, 8'hFF, 8'hFF);
    op(0, 0, 8'h00, "R4");
    op(0, 0, 8'h00, "R4");
    idle();
    // R7: locked unit 3 keeps storage; read back old value
    loadAddr(8'h18, 8'h00, 8'h10);
    op(1, 0, 8'h11, "R7");
    unitLocked = 8'h08;
    loadAddr(8'h18, 8'h00, 8'h10);
    op(1, 0, 8'h99, "R7");
    op(1, 0, 8'h98, "R7");
    unitLocked = 8'h00;
    loadAddr(8'h18, 8'h00, 8'h10);
    op(0, 0, 8'h00, "R7");
    op(0, 0, 8'h00, "R7");
    // R6/R7: absent unit 4 reads 0xFF, writes ignored, address still steps
    unitPresent = 8'hEF;
    loadAddr(8'h20, 8'h00, 8'h05);
    op(1, 0, 8'h77, "R7");
    op(0, 0, 8'h00, "R6");
    unitPresent = 8'hFF;
    loadAddr(8'h20, 8'h00, 8'h05);
    op(0, 0, 8'h00, "R7");
    op(0, 0, 8'h00, "R6");
    // R1: idle cycles leave address alone
    loadAddr(8'h00, 8'h00, 8'h40);
    idle(); idle();
    op(0, 0, 8'h00, "R1");
    idle();
    idle();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    end
    $finish;
  end

  initial begin
    #40000;
    if (!summaryDone) begin
      summaryDone = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule